// File: doc/BRIEF.md
# Multi-Stack Buffer Descriptor Manager

This block keeps a set of independent last-in-first-out stacks of free buffer addresses on chip and serves them through a memory-mapped load/store port. A store whose address falls in the block's region pushes the buffer address carried in the write data onto the stack chosen by address bits [7:3]. A load in the same region pops the top entry of the chosen stack and returns a 64-bit buffer descriptor one cycle later.

The descriptor is rebuilt on every pop. The stored 35-bit address is combined with attributes the block supplies itself: the stack index, a size code taken from a per-stack configuration input, a fixed instance number, a hardware-managed flag and a two-bit status code. A pop from an empty stack does not stall. It returns a descriptor whose status code says that nothing was available. A push to a full stack is discarded and sets a sticky overflow bit for that stack.

Top module: `buf_stack_mgr`

## Requirements
- R1: An access acts only when `req_valid` is high and `req_addr[28:26]` equals 6. Any other access changes no stack, sets no overflow bit and produces no response.
- R2: A push stores only `req_wdata[41:7]`. The write-data bits [63:42] and [6:0] have no effect on any later pop.
- R3: A pop from a non-empty stack returns its most recently pushed entry, with that address in bits [41:7] and status code 0 in bits [63:62], and removes the entry.
- R4: `resp_valid` is high in exactly the one cycle after the clock edge that accepted a load, and low after every other edge.
- R5: Descriptor bits [52:48] carry the stack index taken from `req_addr[7:3]`.
- R6: Descriptor bits [60:58] carry the stack's size code, `cfg_size[3*s+2:3*s]` for stack s. The codes 0 to 7 stand for 128, 256, 512, 1024, 1664, 4096, 10368 and 16384 bytes.
- R7: Descriptor bit 57 is always 1, bits [56:55] equal the parameter `INST_ID`, and bits [54:53], [47:42] and [6:0] are 0.
- R8: A pop from an empty stack returns status code 3 in bits [63:62] and zero in bits [41:7], still fills in the fields of R5 to R7, and leaves the stack unchanged.
- R9: A push to a stack that holds `DEPTH` entries is dropped and leaves the stack's contents unchanged. It sets `ovf_flags[s]`, which then stays set until reset.
- R10: Stacks are independent: pushing to or popping one stack leaves every other stack's contents unchanged.
- R11: After reset every stack is empty, `ovf_flags` is 0 and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = store (push), 0 = load (pop) |
| req_addr | input | ADDR_W | Access address; region in [28:26], stack in [7:3] |
| req_wdata | input | 64 | Store data; buffer address in [41:7] |
| cfg_size | input | 3*NUM_STACKS | Per-stack buffer size codes |
| resp_valid | output | 1 | Load response strobe |
| resp_data | output | 64 | Popped buffer descriptor |
| ovf_flags | output | NUM_STACKS | Sticky per-stack overflow bits |

## Verification
The bench sweeps every stack through empty, full, overflowing and drained again. It computes each descriptor by adding up shifted fields. It does not use the design's packing. An off-by-one in the fill count would let a fifth push overwrite the top entry, or would make the stack report empty one pop too early. Either fault shows up as a wrong address or a wrong status code at the boundary. Write data with all the ignored bits set catches a design that stores more than the address field. Accesses with a wrong region code, and pops from a neighbouring stack, catch decode that is too loose and stacks that share state.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  localparam int          DESC_W      = 64;
  localparam int          VA_W        = 35;
  localparam int          VA_LSB      = 7;
  localparam int          IDX_W       = 5;
  localparam logic [2:0]  REGION_BSM  = 3'd6;
  localparam logic [1:0]  STAT_OK     = 2'b00;
  localparam logic [1:0]  STAT_EMPTY  = 2'b11;

  typedef logic [VA_W-1:0]   va_t;
  typedef logic [DESC_W-1:0] desc_t;

  // Pulls the stored address field out of store data.
  function automatic va_t wdata_va(input desc_t wd);
    return wd[VA_LSB+VA_W-1:VA_LSB];
  endfunction

  // Assembles a descriptor from its fields; all unnamed bits are zero.
  function automatic desc_t build_desc(input logic [1:0]       stat,
                                       input logic [2:0]       size,
                                       input logic [1:0]       inst,
                                       input logic [IDX_W-1:0] idx,
                                       input va_t              va);
    desc_t d;
    d                         = '0;
    d[63:62]                  = stat;
    d[60:58]                  = size;
    d[57]                     = 1'b1;
    d[56:55]                  = inst;
    d[52:48]                  = idx;
    d[VA_LSB+VA_W-1:VA_LSB]   = va;
    return d;
  endfunction

endpackage

// File: rtl/bsm_decode.sv
module bsm_decode #(
  parameter int NUM_STACKS = 32,
  parameter int ADDR_W     = 32
) (
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    hit_push,
  output logic                    hit_pop,
  output logic [bsm_pkg::IDX_W-1:0] sel_raw
);
  import bsm_pkg::*;

  logic region_ok;
  logic in_range;
  logic unused_addr;

  assign sel_raw     = req_addr[7:3];
  assign region_ok   = (req_addr[28:26] == REGION_BSM);
  assign unused_addr = ^{req_addr[ADDR_W-1:29], req_addr[25:8], req_addr[2:0]};

  generate
    if (NUM_STACKS < 32) begin : g_range
      assign in_range = ({1'b0, sel_raw} < 6'(NUM_STACKS));
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign hit_push = req_valid &  req_write & region_ok & in_range;
  assign hit_pop  = req_valid & ~req_write & region_ok & in_range;

endmodule

// File: rtl/bsm_stack.sv
module bsm_stack #(
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  bsm_pkg::va_t    push_va,
  output bsm_pkg::va_t    top_va,
  output logic            empty,
  output logic            full,
  output logic            ovf
);
  import bsm_pkg::*;

  localparam int            CW       = $clog2(DEPTH + 1);
  localparam int            IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  va_t           mem [DEPTH];
  logic [CW-1:0] count;
  logic [CW-1:0] top_pos;
  logic          do_push;
  logic          do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign top_pos = count - CW'(1);
  assign top_va  = empty ? '0 : mem[top_pos[IW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[count[IW-1:0]] <= push_va;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) begin
        count <= count + CW'(1);
      end else if (do_pop) begin
        count <= count - CW'(1);
      end
      if (push & full) begin
        ovf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bsm_resp.sv
module bsm_resp #(
  parameter logic [1:0] INST_ID = 2'd0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pop_fire,
  input  logic                      pop_empty,
  input  logic [bsm_pkg::IDX_W-1:0] idx,
  input  logic [2:0]                size,
  input  bsm_pkg::va_t              va,
  output logic                      resp_valid,
  output bsm_pkg::desc_t            resp_data
);
  import bsm_pkg::*;

  desc_t next_desc;

  always_comb begin
    if (pop_empty) begin
      next_desc = build_desc(STAT_EMPTY, size, INST_ID, idx, '0);
    end else begin
      next_desc = build_desc(STAT_OK, size, INST_ID, idx, va);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= pop_fire;
      if (pop_fire) begin
        resp_data <= next_desc;
      end
    end
  end

endmodule

// File: rtl/buf_stack_mgr.sv
module buf_stack_mgr #(
  parameter int         NUM_STACKS = 32,
  parameter int         DEPTH      = 4,
  parameter int         ADDR_W     = 32,
  parameter logic [1:0] INST_ID    = 2'd0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [63:0]               req_wdata,
  input  logic [3*NUM_STACKS-1:0]   cfg_size,
  output logic                      resp_valid,
  output logic [63:0]               resp_data,
  output logic [NUM_STACKS-1:0]     ovf_flags
);
  import bsm_pkg::*;

  localparam int SEL_W = $clog2(NUM_STACKS);

  // Named internal events, also observed by the bound checker.
  logic                  hit_push;
  logic                  hit_pop;
  logic [IDX_W-1:0]      sel_raw;
  logic [SEL_W-1:0]      sel_idx;
  logic                  pop_empty;
  logic                  push_full;

  va_t                   push_va;
  va_t                   top_va_arr [NUM_STACKS];
  logic [NUM_STACKS-1:0] empty_vec;
  logic [NUM_STACKS-1:0] full_vec;
  va_t                   sel_va;
  logic [2:0]            sel_size;
  logic                  unused_wdata;

  bsm_decode #(
    .NUM_STACKS (NUM_STACKS),
    .ADDR_W     (ADDR_W)
  ) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .hit_push  (hit_push),
    .hit_pop   (hit_pop),
    .sel_raw   (sel_raw)
  );

  assign sel_idx      = sel_raw[SEL_W-1:0];
  assign push_va      = wdata_va(req_wdata);
  assign unused_wdata = ^{req_wdata[63:42], req_wdata[6:0]};

  generate
    for (genvar s = 0; s < NUM_STACKS; s++) begin : g_stack
      logic st_push;
      logic st_pop;
      assign st_push = hit_push & (sel_idx == SEL_W'(s));
      assign st_pop  = hit_pop  & (sel_idx == SEL_W'(s));
      bsm_stack #(
        .DEPTH (DEPTH)
      ) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (st_push),
        .pop     (st_pop),
        .push_va (push_va),
        .top_va  (top_va_arr[s]),
        .empty   (empty_vec[s]),
        .full    (full_vec[s]),
        .ovf     (ovf_flags[s])
      );
    end
  endgenerate

  assign sel_va    = top_va_arr[sel_idx];
  assign sel_size  = cfg_size[3*sel_idx +: 3];
  assign pop_empty = empty_vec[sel_idx];
  assign push_full = full_vec[sel_idx];

  bsm_resp #(
    .INST_ID (INST_ID)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_fire   (hit_pop),
    .pop_empty  (pop_empty),
    .idx        (sel_raw),
    .size       (sel_size),
    .va         (sel_va),
    .resp_valid (resp_valid),
    .resp_data  (resp_data)
  );

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int         NUM_STACKS = 32,
  parameter int         SEL_W      = 5,
  parameter logic [1:0] INST_ID    = 2'd0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  hit_pop,
  input logic                  hit_push,
  input logic                  pop_empty,
  input logic                  push_full,
  input logic [4:0]            sel_raw,
  input logic [SEL_W-1:0]      sel_idx,
  input logic                  resp_valid,
  input logic [63:0]           resp_data,
  input logic [NUM_STACKS-1:0] ovf_flags
);

  assert_resp_follows_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pop |=> resp_valid);

  assert_no_spurious_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_pop |=> !resp_valid);

  assert_ok_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pop && !pop_empty) |=> (resp_data[63:62] == 2'b00));

  assert_empty_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pop && pop_empty) |=> (resp_data[63:62] == 2'b11 && resp_data[41:7] == '0));

  assert_index_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pop |=> (resp_data[52:48] == $past(sel_raw)));

  assert_fixed_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_data[57] && resp_data[56:55] == INST_ID));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ovf_flags & $past(ovf_flags)) == '0));

  assert_ovf_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_push && push_full) |=> ovf_flags[$past(sel_idx)]);

endmodule

bind buf_stack_mgr bsm_checker #(
  .NUM_STACKS (NUM_STACKS),
  .SEL_W      (SEL_W),
  .INST_ID    (INST_ID)
) u_bsm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_pop    (hit_pop),
  .hit_push   (hit_push),
  .pop_empty  (pop_empty),
  .push_full  (push_full),
  .sel_raw    (sel_raw),
  .sel_idx    (sel_idx),
  .resp_valid (resp_valid),
  .resp_data  (resp_data),
  .ovf_flags  (ovf_flags)
);

// File: tb/test_buf_stack_mgr.sv
module test_buf_stack_mgr;

  localparam int         NS    = 32;
  localparam int         DEP   = 4;
  localparam int         AW    = 32;
  localparam logic [1:0] INST  = 2'd2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [AW-1:0]     req_addr;
  logic [63:0]       req_wdata;
  logic [3*NS-1:0]   cfg_size;
  logic              resp_valid;
  logic [63:0]       resp_data;
  logic [NS-1:0]     ovf_flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  buf_stack_mgr #(
    .NUM_STACKS (NS),
    .DEPTH      (DEP),
    .ADDR_W     (AW),
    .INST_ID    (INST)
  ) i_buf_stack_mgr (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .cfg_size   (cfg_size),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .ovf_flags  (ovf_flags)
  );

  function automatic logic [2:0] size_of(input int s);
    return 3'((s * 5 + 3) % 8);
  endfunction

  function automatic logic [34:0] va_of(input int s, input int i);
    logic [34:0] v;
    v = 35'h4_0000_0000 + 35'(s) * 35'h10_0000 + 35'(i) * 35'd12345 + 35'd7;
    return v;
  endfunction

  // Expected descriptor as a sum of shifted fields.
  function automatic logic [63:0] exp_desc(input int s, input bit emp, input logic [34:0] va);
    logic [63:0] d;
    d = (emp ? (64'd3 << 62) : 64'd0)
      + (64'(size_of(s)) << 58)
      + (64'd1 << 57)
      + (64'(INST) << 55)
      + (64'(s) << 48)
      + (emp ? 64'd0 : (64'(va) << 7));
    return d;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input logic [2:0] rgn, input int s);
    return (AW'(rgn) << 26) | (AW'(s) << 3) | AW'(32'h8000_0005);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Called at a negedge; returns at the next negedge with any response visible.
  task automatic op(input bit wr, input int s, input logic [2:0] rgn, input logic [63:0] wd);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = mk_addr(rgn, s);
    req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push(input int s, input logic [34:0] va);
    op(1'b1, s, 3'd6, {22'h3A_5A5A, va, 7'h7F});
  endtask

  task automatic pop_check(input string req, input int s, input bit emp, input logic [34:0] va);
    op(1'b0, s, 3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    check({req, " resp_valid"}, 64'(resp_valid), 64'd1);
    check(req, resp_data, exp_desc(s, emp, va));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [NS-1:0] exp_ovf;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    for (int s = 0; s < NS; s++) cfg_size[3*s +: 3] = size_of(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 resp_valid", 64'(resp_valid), 64'd0);
    check("R11 ovf_flags", 64'(ovf_flags), 64'd0);

    // R1 wrong region: load gives no response, store changes nothing
    op(1'b0, 1, 3'd5, 64'd0);
    check("R1 foreign load no response", 64'(resp_valid), 64'd0);
    op(1'b1, 1, 3'd7, {22'd0, va_of(1, 9), 7'd0});
    check("R1 foreign store no response", 64'(resp_valid), 64'd0);
    pop_check("R1 foreign store not stored", 1, 1'b1, '0);

    // Sweep every stack: empty, fill, overflow, drain
    exp_ovf = '0;
    for (int s = 0; s < NS; s++) begin
      pop_check("R8 empty pop", s, 1'b1, '0);
      for (int i = 0; i < DEP; i++) begin
        push(s, va_of(s, i));
        check("R4 no response to store", 64'(resp_valid), 64'd0);
      end
      check("R9 no overflow at exact fill", 64'(ovf_flags), 64'(exp_ovf));
      push(s, va_of(s, 99));
      exp_ovf[s] = 1'b1;
      check("R9 overflow flag", 64'(ovf_flags), 64'(exp_ovf));
      for (int i = DEP - 1; i >= 0; i--) begin
        pop_check("R3 R2 R5 R6 R7 LIFO pop", s, 1'b0, va_of(s, i));
      end
      pop_check("R8 drained pop", s, 1'b1, '0);
      @(negedge clk);
      check("R4 single-cycle response", 64'(resp_valid), 64'd0);
      check("R9 flag sticky", 64'(ovf_flags), 64'(exp_ovf));
    end

    // R10 independence between neighbouring stacks
    push(7, va_of(7, 50));
    pop_check("R10 neighbour untouched", 8, 1'b1, '0);
    pop_check("R10 own entry kept", 7, 1'b0, va_of(7, 50));

    // R8 empty pop leaves the stack unchanged
    push(12, va_of(12, 3));
    pop_check("R8 pop returns entry", 12, 1'b0, va_of(12, 3));
    pop_check("R8 empty pop once", 12, 1'b1, '0);
    push(12, va_of(12, 4));
    pop_check("R8 stack usable after empty pop", 12, 1'b0, va_of(12, 4));

    report();
  end

endmodule